// File: doc/BRIEF.md
# Hit-Pattern Latency Ring with Event Capture

This block keeps a circular store of the 16-bit counter pattern that one pattern group produces on every processing tick. The store is written once per clock and never stalls, so the most recent ticks are always on hand. A trigger-accept pulse marks an event. The block then copies a fixed window of eight consecutive stored words, which sits a set number of ticks behind the trigger, into an event FIFO. A downstream formatter drains that FIFO through a simple show-ahead read port.

Two settings decide what reaches the FIFO. The recording setting stores either every pattern, or only the patterns flagged as part of a found segment, with all other slots written as zero. The readout setting, which is captured with each trigger, forwards either all eight words or only the first one or first two non-zero words of the window. A trigger that arrives while a copy is running waits in a short queue. When the queue is full, the trigger is dropped and a sticky overflow bit is set.

Top module: `hit_ring_capture`

## Requirements
- R1: The ring takes one new word on every clock after reset, with no pause. The word of tick t sits in slot t modulo RING_DEPTH, where tick 0 is the first rising edge after reset is released.
- R2: When `best_mode_i` is 0, the stored word is `pat_i` unchanged.
- R3: When `best_mode_i` is 1, the stored word is `pat_i` if `seg_i` is 1 and zero otherwise.
- R4: A trigger sampled at tick T selects the stored words of ticks T-TRIG_LAT up to T-TRIG_LAT+7. These words are delivered oldest first, so the window starts at the write slot of tick T minus TRIG_LAT, modulo RING_DEPTH.
- R5: With `sparse_mode_i` = 0, all eight window words are pushed to the event FIFO, zero words included.
- R6: With `sparse_mode_i` = 1, only the first non-zero window word is pushed.
- R7: With `sparse_mode_i` = 2 or 3, only the first two non-zero window words are pushed, in window order.
- R8: In either sparse setting, a window with no non-zero word pushes exactly one zero word.
- R9: A trigger that arrives during a copy is queued, up to TQ_DEPTH pending triggers. Events reach the FIFO in trigger order. From idle, three triggers on back-to-back ticks are all kept.
- R10: A trigger that finds the queue full is dropped and sets `overflow_o`, which stays 1 until reset. From idle, four back-to-back triggers drop the fourth one only.
- R11: After reset, `ev_empty_o` = 1, `ev_valid_o` = 0 and `overflow_o` = 0.
- R12: `ev_data_o` shows the oldest FIFO word while `ev_valid_o` = 1, and `ev_valid_o` is the inverse of `ev_empty_o`. A rising edge with `rd_en_i` = 1 and the FIFO not empty removes that word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processing clock, one tick per edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pat_i | input | PAT_W | Counter pattern of the current tick |
| seg_i | input | 1 | Current tick's pattern belongs to a found segment |
| trig_i | input | 1 | Trigger-accept pulse, one per event |
| best_mode_i | input | 1 | 0 = store every pattern, 1 = store segment patterns only |
| sparse_mode_i | input | 2 | 0 = all words, 1 = first non-zero, 2/3 = first two non-zero |
| rd_en_i | input | 1 | Remove the word shown on ev_data_o |
| ev_data_o | output | PAT_W | Oldest event FIFO word |
| ev_valid_o | output | 1 | ev_data_o holds a word |
| ev_empty_o | output | 1 | Event FIFO holds no word |
| overflow_o | output | 1 | Sticky flag: a trigger was dropped |

## Verification
Random patterns, about a third of them zero, are mixed with random segment flags. This tells a window that is shifted by one tick from the correct one, and it shows whether zeros from segment-only recording are ignored or forwarded by the sparse readouts. Long runs of all-zero patterns isolate the single-zero-word rule, and they also show that full readout still produces eight words. Triggers on back-to-back ticks, three and then four in a row, separate correct queueing and ordering from premature or missing overflow. A randomly gated read enable checks that FIFO backpressure loses no words and reorders none.

// File: rtl/hrc_pkg.sv
package hrc_pkg;

  // slot that lies 'lat' entries behind 'ptr' in a ring of 'depth'
  function automatic int unsigned ring_back(int unsigned ptr, int unsigned lat,
                                            int unsigned depth);
    return (ptr + depth - (lat % depth)) % depth;
  endfunction

  // slot that lies 'step' entries ahead of 'ptr'
  function automatic int unsigned ring_fwd(int unsigned ptr, int unsigned step,
                                           int unsigned depth);
    return (ptr + step) % depth;
  endfunction

  // number of non-zero words a readout setting lets through (0 = no limit)
  function automatic int unsigned sparse_limit(logic [1:0] mode);
    case (mode)
      2'd0:    return 0;
      2'd1:    return 1;
      default: return 2;
    endcase
  endfunction

  // decide whether the current window word goes to the event FIFO
  function automatic logic keep_word(logic nonzero, int unsigned kept,
                                     logic [1:0] mode, logic last);
    int unsigned lim;
    lim = sparse_limit(mode);
    if (lim == 0) return 1'b1;
    if (nonzero && (kept < lim)) return 1'b1;
    if (last && (kept == 0)) return 1'b1;
    return 1'b0;
  endfunction

endpackage

// File: rtl/hrc_ring.sv
module hrc_ring #(
  parameter int W     = 16,
  parameter int DEPTH = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     best_i,
  input  logic                     seg_i,
  input  logic [W-1:0]             pat_i,
  input  logic [$clog2(DEPTH)-1:0] rd_addr_i,
  output logic [W-1:0]             rd_data_o,
  output logic [$clog2(DEPTH)-1:0] wr_ptr_o
);
  import hrc_pkg::*;
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [W-1:0]  rec_word;

  // segment-only recording zeroes patterns without the segment flag
  assign rec_word = (best_i && !seg_i) ? '0 : pat_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_ptr <= '0;
    else        wr_ptr <= AW'(ring_fwd(wr_ptr, 1, DEPTH));
  end

  always_ff @(posedge clk) begin
    mem[wr_ptr] <= rec_word;
  end

  assign rd_data_o = mem[rd_addr_i];
  assign wr_ptr_o  = wr_ptr;

  // R2: raw recording keeps the pattern as presented
  a_r2_raw_copy: assert property (@(posedge clk) disable iff (!rst_n)
    !best_i |=> mem[$past(wr_ptr)] == $past(pat_i));
  // R3: unflagged ticks are stored as zero in segment-only recording
  a_r3_best_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (best_i && !seg_i) |=> mem[$past(wr_ptr)] == '0);
  // R1: the write slot moves on every tick
  a_r1_never_pause: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> wr_ptr != $past(wr_ptr));
endmodule

// File: rtl/hrc_trig_queue.sv
module hrc_trig_queue #(
  parameter int AW     = 6,
  parameter int QDEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig_i,
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    mode_i,
  input  logic          pop_i,
  output logic [AW-1:0] head_addr_o,
  output logic [1:0]    head_mode_o,
  output logic          avail_o,
  output logic          full_o,
  output logic          ovf_o
);
  localparam int QAW = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
  localparam int CW  = $clog2(QDEPTH + 1);

  logic [AW-1:0]  q_addr [QDEPTH];
  logic [1:0]     q_mode [QDEPTH];
  logic [QAW-1:0] wp, rp;
  logic [CW-1:0]  cnt;
  logic           push, pop;

  assign full_o  = (cnt == CW'(QDEPTH));
  assign avail_o = (cnt != '0);
  assign push    = trig_i && !full_o;
  assign pop     = pop_i && avail_o;

  function automatic logic [QAW-1:0] q_next(logic [QAW-1:0] p);
    return (p == QAW'(QDEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      cnt   <= '0;
      ovf_o <= 1'b0;
    end else begin
      if (push) wp <= q_next(wp);
      if (pop)  rp <= q_next(rp);
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
      if (trig_i && full_o) ovf_o <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      q_addr[wp] <= addr_i;
      q_mode[wp] <= mode_i;
    end
  end

  assign head_addr_o = q_addr[rp];
  assign head_mode_o = q_mode[rp];

  // R10: the overflow flag never clears on its own
  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> ovf_o);
  // R10: a trigger meeting a full queue is reported
  a_r10_ovf_on_full: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && full_o) |=> ovf_o);
  // R9: the copy engine only takes a pending trigger
  a_r9_pop_pending: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> avail_o);
endmodule

// File: rtl/hrc_xfer.sv
module hrc_xfer #(
  parameter int W     = 16,
  parameter int DEPTH = 64,
  parameter int EVW   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     avail_i,
  input  logic [$clog2(DEPTH)-1:0] head_addr_i,
  input  logic [1:0]               head_mode_i,
  output logic                     pop_o,
  output logic [$clog2(DEPTH)-1:0] ring_addr_o,
  input  logic [W-1:0]             ring_data_i,
  input  logic                     fifo_full_i,
  output logic                     push_o,
  output logic [W-1:0]             push_data_o
);
  import hrc_pkg::*;
  localparam int AW = $clog2(DEPTH);
  localparam int IW = $clog2(EVW + 1);

  logic          busy_q;
  logic [AW-1:0] base_q;
  logic [1:0]    mode_q;
  logic [IW-1:0] idx_q, kept_q;
  logic          step, last, keep, ev_done;
  logic [IW:0]   ev_total;

  assign pop_o       = !busy_q && avail_i;
  assign ring_addr_o = AW'(ring_fwd(base_q, idx_q, DEPTH));
  assign step        = busy_q && !fifo_full_i;
  assign last        = (idx_q == IW'(EVW - 1));
  assign keep        = keep_word(ring_data_i != '0, kept_q, mode_q, last);
  assign push_o      = step && keep;
  assign push_data_o = ring_data_i;
  assign ev_done     = step && last;
  assign ev_total    = {1'b0, kept_q} + (IW+1)'(push_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      base_q <= '0;
      mode_q <= '0;
      idx_q  <= '0;
      kept_q <= '0;
    end else if (pop_o) begin
      busy_q <= 1'b1;
      base_q <= head_addr_i;
      mode_q <= head_mode_i;
      idx_q  <= '0;
      kept_q <= '0;
    end else if (step) begin
      idx_q  <= idx_q + 1'b1;
      kept_q <= kept_q + IW'(keep);
      if (last) busy_q <= 1'b0;
    end
  end

  // R5: full readout delivers every window word
  a_r5_full_count: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_done && mode_q == 2'd0) |-> ev_total == (IW+1)'(EVW));
  // R6 R7 R8: sparse readout delivers at least one and at most its limit
  a_r8_sparse_count: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_done && mode_q != 2'd0) |->
      (ev_total >= 1 && ev_total <= (IW+1)'(sparse_limit(mode_q))));
  // R9: a new event is never started while one is being copied
  a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !pop_o);
endmodule

// File: rtl/hrc_evfifo.sv
module hrc_evfifo #(
  parameter int W     = 16,
  parameter int DEPTH = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] push_data_i,
  input  logic         rd_i,
  output logic [W-1:0] data_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_wr, do_rd;

  assign empty_o = (cnt == '0);
  assign full_o  = (cnt == CW'(DEPTH));
  assign do_wr   = push_i && !full_o;
  assign do_rd   = rd_i && !empty_o;
  assign data_o  = mem[rp];

  function automatic logic [AW-1:0] f_next(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_wr) wp <= f_next(wp);
      if (do_rd) rp <= f_next(rp);
      case ({do_wr, do_rd})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= push_data_i;
  end

  // R12: the copy engine holds off while the FIFO is full
  a_r12_push_not_full: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> !full_o);
  // R12: a read of a one-word FIFO with no write leaves it empty
  a_r12_read_drains: assert property (@(posedge clk) disable iff (!rst_n)
    (do_rd && !do_wr && cnt == CW'(1)) |=> empty_o);
endmodule

// File: rtl/hit_ring_capture.sv
module hit_ring_capture #(
  parameter int PAT_W      = 16,
  parameter int RING_DEPTH = 64,
  parameter int TRIG_LAT   = 24,
  parameter int EVT_WORDS  = 8,
  parameter int FIFO_DEPTH = 32,
  parameter int TQ_DEPTH   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PAT_W-1:0] pat_i,
  input  logic             seg_i,
  input  logic             trig_i,
  input  logic             best_mode_i,
  input  logic [1:0]       sparse_mode_i,
  input  logic             rd_en_i,
  output logic [PAT_W-1:0] ev_data_o,
  output logic             ev_valid_o,
  output logic             ev_empty_o,
  output logic             overflow_o
);
  import hrc_pkg::*;
  localparam int RING_AW = $clog2(RING_DEPTH);

  logic [RING_AW-1:0] wr_ptr, start_addr, head_addr, ring_addr;
  logic [PAT_W-1:0]   ring_data, push_data;
  logic [1:0]         head_mode;
  logic               q_avail, q_full, q_pop, f_push, f_full;

  // window start: current write slot moved back by the trigger latency
  assign start_addr = RING_AW'(ring_back(wr_ptr, TRIG_LAT, RING_DEPTH));

  hrc_ring #(.W(PAT_W), .DEPTH(RING_DEPTH)) ring_i (
    .clk(clk), .rst_n(rst_n), .best_i(best_mode_i), .seg_i(seg_i),
    .pat_i(pat_i), .rd_addr_i(ring_addr), .rd_data_o(ring_data),
    .wr_ptr_o(wr_ptr));

  hrc_trig_queue #(.AW(RING_AW), .QDEPTH(TQ_DEPTH)) tq_i (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .addr_i(start_addr),
    .mode_i(sparse_mode_i), .pop_i(q_pop), .head_addr_o(head_addr),
    .head_mode_o(head_mode), .avail_o(q_avail), .full_o(q_full),
    .ovf_o(overflow_o));

  hrc_xfer #(.W(PAT_W), .DEPTH(RING_DEPTH), .EVW(EVT_WORDS)) xfer_i (
    .clk(clk), .rst_n(rst_n), .avail_i(q_avail), .head_addr_i(head_addr),
    .head_mode_i(head_mode), .pop_o(q_pop), .ring_addr_o(ring_addr),
    .ring_data_i(ring_data), .fifo_full_i(f_full), .push_o(f_push),
    .push_data_o(push_data));

  hrc_evfifo #(.W(PAT_W), .DEPTH(FIFO_DEPTH)) fifo_i (
    .clk(clk), .rst_n(rst_n), .push_i(f_push), .push_data_i(push_data),
    .rd_i(rd_en_i), .data_o(ev_data_o), .empty_o(ev_empty_o),
    .full_o(f_full));

  assign ev_valid_o = !ev_empty_o;

  // R10: no overflow while the queue still has room
  a_r10_no_false_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (!overflow_o && !(trig_i && q_full)) |=> !overflow_o);
endmodule

// File: tb/hit_ring_capture_tb_top.sv
module hit_ring_capture_tb_top;
  localparam int LAT = 24;
  localparam int EVW = 8;
  localparam int HN  = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] pat_i = '0;
  logic        seg_i = 1'b0, trig_i = 1'b0, best_mode_i = 1'b0;
  logic [1:0]  sparse_mode_i = '0;
  logic        rd_en_i = 1'b0;
  logic [15:0] ev_data_o;
  logic        ev_valid_o, ev_empty_o, overflow_o;

  int n_checks = 0, n_fails = 0, tick = 0;
  bit done = 1'b0;
  logic [15:0] hist [HN];
  logic [15:0] exp_q [$];
  string       tag_q [$];

  always #4 clk = ~clk;

  hit_ring_capture #(.RING_DEPTH(64), .TRIG_LAT(LAT), .EVT_WORDS(EVW))
    dut_i (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected output of one event, built from the bench's own history
  function automatic void build_event(int t, logic [1:0] m);
    logic [15:0] win [EVW];
    logic [15:0] nz [$];
    int lim;
    for (int k = 0; k < EVW; k++) win[k] = hist[(t - LAT + k + HN) % HN];
    if (m == 2'd0) begin
      for (int k = 0; k < EVW; k++) begin exp_q.push_back(win[k]); tag_q.push_back("R1 R4 R5"); end
      return;
    end
    lim = (m == 2'd1) ? 1 : 2;
    for (int k = 0; k < EVW; k++) if (win[k] != 0) nz.push_back(win[k]);
    if (nz.size() == 0) begin
      exp_q.push_back(16'h0); tag_q.push_back("R8");
    end else begin
      for (int k = 0; k < nz.size() && k < lim; k++) begin
        exp_q.push_back(nz[k]);
        tag_q.push_back(lim == 1 ? "R4 R6" : "R4 R7");
      end
    end
  endfunction

  task automatic drive(input logic [15:0] p, input logic s, input logic t,
                       input logic [1:0] sp, input bit drop);
    pat_i = p; seg_i = s; trig_i = t; sparse_mode_i = sp;
    hist[tick % HN] = (best_mode_i && !s) ? 16'h0 : p;   // R2 R3
    if (t && !drop) build_event(tick, sp);
    @(posedge clk);
    tick++;
    @(negedge clk);
  endtask

  function automatic logic [15:0] rnd_pat();
    return ($urandom % 3 == 0) ? 16'h0 : 16'($urandom);
  endfunction

  task automatic drain();
    for (int i = 0; i < 400 && exp_q.size() != 0; i++)
      drive(rnd_pat(), 1'($urandom), 1'b0, 2'd0, 1'b0);
    repeat (3) drive(rnd_pat(), 1'b0, 1'b0, 2'd0, 1'b0);
  endtask

  // reader: decides rd_en for the coming edge, then checks the word it takes (R12)
  initial begin
    forever begin
      @(negedge clk);
      rd_en_i = ($urandom % 4) != 0;
      if (rst_n && !done) begin
        if (ev_valid_o == ev_empty_o) check(1'b0, "R12 valid/empty", ev_valid_o, !ev_empty_o);
        if (rd_en_i && ev_valid_o) begin
          if (exp_q.size() == 0) check(1'b0, "R9 unexpected word", ev_data_o, 0);
          else begin
            logic [15:0] e;
            string tg;
            e = exp_q.pop_front(); tg = tag_q.pop_front();
            check(ev_data_o == e, tg, ev_data_o, e);
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      check(1'b0, "watchdog", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    int gap;
    void'($urandom(32'h1C0FFEE));
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    check(ev_empty_o == 1'b1, "R11 empty", ev_empty_o, 1);
    check(ev_valid_o == 1'b0, "R11 valid", ev_valid_o, 0);
    check(overflow_o == 1'b0, "R11 overflow", overflow_o, 0);
    rst_n = 1'b1;
    tick = 0;
    repeat (40) drive(rnd_pat(), 1'b0, 1'b0, 2'd0, 1'b0);
    // R8 and R5: windows made entirely of zeros
    repeat (32) drive(16'h0, 1'b0, 1'b0, 2'd0, 1'b0);
    drive(16'h0, 1'b0, 1'b1, 2'd1, 1'b0);
    repeat (12) drive(16'h0, 1'b0, 1'b0, 2'd0, 1'b0);
    drive(16'h0, 1'b0, 1'b1, 2'd2, 1'b0);
    repeat (12) drive(16'h0, 1'b0, 1'b0, 2'd0, 1'b0);
    drive(16'h0, 1'b0, 1'b1, 2'd0, 1'b0);
    drain();
    check(ev_empty_o == 1'b1, "R8 all consumed", ev_empty_o, 1);
    // R6 R7: sparse patterns with one isolated non-zero word
    repeat (30) drive(16'h0, 1'b0, 1'b0, 2'd0, 1'b0);
    drive(16'hA5A5, 1'b0, 1'b0, 2'd0, 1'b0);
    repeat (LAT - 3) drive(16'h0, 1'b0, 1'b0, 2'd0, 1'b0);
    drive(16'h0, 1'b0, 1'b1, 2'd2, 1'b0);
    drain();
    // random phase: mixed modes, triggers spaced so the queue stays short
    gap = 0;
    for (int i = 0; i < 1500; i++) begin
      logic t;
      if (i % 250 == 0) best_mode_i = 1'($urandom);
      t = (gap >= 12) && ($urandom % 8 == 0);
      gap = t ? 0 : gap + 1;
      drive(rnd_pat(), ($urandom % 4) == 0, t, 2'($urandom), 1'b0);
    end
    drain();
    best_mode_i = 1'b0;
    // R9: three back-to-back triggers are all queued
    drive(rnd_pat(), 1'b0, 1'b1, 2'd0, 1'b0);
    drive(rnd_pat(), 1'b0, 1'b1, 2'd1, 1'b0);
    drive(rnd_pat(), 1'b0, 1'b1, 2'd0, 1'b0);
    drain();
    check(overflow_o == 1'b0, "R9 R10 no overflow after three", overflow_o, 0);
    // R10: the fourth back-to-back trigger is dropped
    drive(rnd_pat(), 1'b0, 1'b1, 2'd0, 1'b0);
    drive(rnd_pat(), 1'b0, 1'b1, 2'd0, 1'b0);
    drive(rnd_pat(), 1'b0, 1'b1, 2'd2, 1'b0);
    drive(rnd_pat(), 1'b0, 1'b1, 2'd0, 1'b1);
    drain();
    check(overflow_o == 1'b1, "R10 overflow set", overflow_o, 1);
    repeat (20) drive(rnd_pat(), 1'b0, 1'b0, 2'd0, 1'b0);
    check(overflow_o == 1'b1, "R10 overflow sticky", overflow_o, 1);
    check(exp_q.size() == 0, "R9 all events delivered", exp_q.size(), 0);
    check(ev_empty_o == 1'b1, "R12 empty at end", ev_empty_o, 1);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule